// File: doc/BRIEF.md
# Hardware Repeat-Block Loop Controller

This block sits next to a program counter and lets a contiguous run of 16-bit instruction words execute several times in a row without any branch instruction. A start command hands it the block length in words, a repeat count and the address of the first word of the block. From then on the controller compares every fetch address with the last word of the block. On a match with repeats still pending, it raises a redirect strobe and gives the block's first address in the same cycle, and it counts one repeat off. On a match with the count at zero, it lets fetch run on past the block and goes idle. A block with count N therefore runs N+1 times.

Interrupts suspend the loop. On interrupt entry the active flag moves into a shadow flag, so a handler that happens to fetch the end address is never redirected. On interrupt return the shadow flag moves back. All state can be read as a 32-bit status word, and nothing can write it except the block's own commands. A start command whose length is too short for the parity of its start address is refused. The refusal shows as a one-cycle error pulse.

Top module: `hwloop_ctrl`

## Requirements
- R1: After a synchronous reset the status word, `redirect_o` and `cfg_err_o` are all zero.
- R2: The status word is `{shadow[31], active[30], size[29:23], end_lo[22:16], count[15:0]}`. `end_lo` holds the low 7 bits of start address plus size minus one.
- R3: In the cycle after an accepted start, the status word shows active=1, the commanded size, the commanded count and the end field from R2.
- R4: A start is accepted when size >= 9, or when size == 8 and start address bit 0 is 1. Any other start drives `cfg_err_o` high for exactly the following cycle and clears active. It leaves size, end field and count unchanged.
- R5: When active is set, the fetch address equals the block end and the count is nonzero, `redirect_o` is high in that same cycle and `redirect_addr_o` equals the start address. The count is one lower in the next cycle.
- R6: When active is set, the fetch address equals the block end and the count is zero, no redirect is issued and active reads 0 in the next cycle. A block with count N therefore produces exactly N redirects.
- R7: While active is clear, `redirect_o` stays low and the count does not change.
- R8: On interrupt entry the shadow flag takes the old active value and active becomes 0 in the next cycle.
- R9: On interrupt return active takes the old shadow value and the shadow flag becomes 0 in the next cycle.
- R10: Priority per cycle is start, then interrupt entry, then interrupt return, then loop stepping. `redirect_o` is low in any cycle where start, interrupt entry or interrupt return is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command strobe |
| start_size_i | input | 7 | Block length in 16-bit words |
| start_count_i | input | 16 | Number of extra passes |
| start_addr_i | input | ADDR_W | Address of the block's first word |
| fetch_addr_i | input | ADDR_W | Current fetch address |
| irq_enter_i | input | 1 | Interrupt entry strobe |
| irq_return_i | input | 1 | Interrupt return strobe |
| redirect_o | output | 1 | Jump back to the block start this cycle |
| redirect_addr_o | output | ADDR_W | Block start address |
| cfg_err_o | output | 1 | Rejected start, one-cycle pulse |
| status_o | output | 32 | Read-only status word |

## Verification
Status fields and `cfg_err_o` come from registers. They are due one clock edge after the command that changes them, so the bench drives on the falling edge and reads them on the next falling edge. `redirect_o` is decided in the same cycle from the fetch address. The bench checks it one nanosecond after driving the fetch address, before the rising edge that updates the count. A model in the bench keeps its own program counter and remaining-pass count and predicts the redirect for every fetch. Every block size at both start parities is swept to check the acceptance rule.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  localparam int SIZE_W   = 7;
  localparam int CNT_W    = 16;
  localparam int ENDF_W   = 7;
  localparam int MIN_ODD  = 8;
  localparam int MIN_EVEN = 9;

  typedef struct packed {
    logic              shadow;
    logic              active;
    logic [SIZE_W-1:0] size;
    logic [ENDF_W-1:0] end_lo;
    logic [CNT_W-1:0]  count;
  } hwloop_status_t;
endpackage

// File: rtl/hwloop_cfg_check.sv
module hwloop_cfg_check #(
  parameter int SIZE_W   = 7,
  parameter int MIN_ODD  = 8,
  parameter int MIN_EVEN = 9
) (
  input  logic [SIZE_W-1:0] size_i,
  input  logic              odd_i,
  output logic              legal_o
);
  localparam logic [SIZE_W-1:0] LIM_ODD  = SIZE_W'(MIN_ODD);
  localparam logic [SIZE_W-1:0] LIM_EVEN = SIZE_W'(MIN_EVEN);

  always_comb begin
    if (odd_i) legal_o = (size_i >= LIM_ODD);
    else       legal_o = (size_i >= LIM_EVEN);
  end
endmodule

// File: rtl/hwloop_counter.sv
module hwloop_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/hwloop_flags.sv
module hwloop_flags (
  input  logic clk,
  input  logic rst,
  input  logic start_ok_i,
  input  logic start_bad_i,
  input  logic irq_enter_i,
  input  logic irq_return_i,
  input  logic loop_done_i,
  output logic active_o,
  output logic shadow_o
);
  logic active_q, shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      shadow_q <= 1'b0;
    end else if (start_ok_i) begin
      active_q <= 1'b1;
    end else if (start_bad_i) begin
      active_q <= 1'b0;
    end else if (irq_enter_i) begin
      shadow_q <= active_q;
      active_q <= 1'b0;
    end else if (irq_return_i) begin
      active_q <= shadow_q;
      shadow_q <= 1'b0;
    end else if (loop_done_i) begin
      active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign shadow_o = shadow_q;
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [6:0]        start_size_i,
  input  logic [15:0]       start_count_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              irq_enter_i,
  input  logic              irq_return_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_addr_o,
  output logic              cfg_err_o,
  output logic [31:0]       status_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic              legal, start_ok, start_bad, quiet, hit, step;
  logic              active, shadow, cnt_zero, dec;
  logic [CNT_W-1:0]  cnt;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] base_q, end_q, end_calc;
  logic              err_q;
  hwloop_status_t    stat;

  hwloop_cfg_check #(
    .SIZE_W  (SIZE_W),
    .MIN_ODD (MIN_ODD),
    .MIN_EVEN(MIN_EVEN)
  ) u_cfg (
    .size_i (start_size_i),
    .odd_i  (start_addr_i[0]),
    .legal_o(legal)
  );

  assign start_ok  = start_i & legal;
  assign start_bad = start_i & ~legal;
  assign quiet     = ~start_i & ~irq_enter_i & ~irq_return_i;
  assign hit       = active & (fetch_addr_i == end_q);
  assign step      = quiet & hit;
  assign dec       = step & ~cnt_zero;
  assign end_calc  = start_addr_i + ADDR_W'(start_size_i) - ONE;

  hwloop_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load_i    (start_ok),
    .load_val_i(start_count_i),
    .dec_i     (dec),
    .cnt_o     (cnt),
    .zero_o    (cnt_zero)
  );

  hwloop_flags u_flags (
    .clk         (clk),
    .rst         (rst),
    .start_ok_i  (start_ok),
    .start_bad_i (start_bad),
    .irq_enter_i (irq_enter_i),
    .irq_return_i(irq_return_i),
    .loop_done_i (step & cnt_zero),
    .active_o    (active),
    .shadow_o    (shadow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= '0;
      base_q <= '0;
      end_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= start_bad;
      if (start_ok) begin
        size_q <= start_size_i;
        base_q <= start_addr_i;
        end_q  <= end_calc;
      end
    end
  end

  always_comb begin
    stat.shadow = shadow;
    stat.active = active;
    stat.size   = size_q;
    stat.end_lo = end_q[ENDF_W-1:0];
    stat.count  = cnt;
  end

  assign status_o        = stat;
  assign redirect_o      = dec;
  assign redirect_addr_o = base_q;
  assign cfg_err_o       = err_q;
endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        start_i,
  input logic [6:0]  start_size_i,
  input logic [15:0] start_count_i,
  input logic        start_lsb,
  input logic [6:0]  fetch_lo,
  input logic        irq_enter_i,
  input logic        irq_return_i,
  input logic        redirect_o,
  input logic        cfg_err_o,
  input logic [31:0] status_o
);
  logic ok_cfg;
  assign ok_cfg = (start_size_i > 7'd8) || (start_size_i == 7'd8 && start_lsb);

  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    start_i && ok_cfg |=> status_o[30] && status_o[29:23] == $past(start_size_i)
                          && status_o[15:0] == $past(start_count_i)); // R3
  AST_BAD_START: assert property (@(posedge clk) disable iff (rst)
    start_i && !ok_cfg |=> cfg_err_o && !status_o[30]); // R4
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !cfg_err_o); // R4
  AST_REDIRECT_DEC: assert property (@(posedge clk) disable iff (rst)
    redirect_o |=> status_o[15:0] == $past(status_o[15:0]) - 16'd1); // R5
  AST_REDIRECT_END: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> fetch_lo == status_o[22:16] && status_o[15:0] != 16'd0); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !status_o[30] |-> !redirect_o); // R7
  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (rst)
    !start_i && !status_o[30] |=> $stable(status_o[15:0])); // R7
  AST_IRQ_SAVE: assert property (@(posedge clk) disable iff (rst)
    !start_i && irq_enter_i |=> !status_o[30] && status_o[31] == $past(status_o[30])); // R8
  AST_IRQ_RESTORE: assert property (@(posedge clk) disable iff (rst)
    !start_i && !irq_enter_i && irq_return_i
      |=> !status_o[31] && status_o[30] == $past(status_o[31])); // R9
  AST_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    start_i || irq_enter_i || irq_return_i |-> !redirect_o); // R10
endmodule

bind hwloop_ctrl hwloop_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .start_size_i (start_size_i),
  .start_count_i(start_count_i),
  .start_lsb    (start_addr_i[0]),
  .fetch_lo     (fetch_addr_i[6:0]),
  .irq_enter_i  (irq_enter_i),
  .irq_return_i (irq_return_i),
  .redirect_o   (redirect_o),
  .cfg_err_o    (cfg_err_o),
  .status_o     (status_o)
);

// File: tb/hwloop_ctrl_tb.sv
`timescale 1ns/1ps
module hwloop_ctrl_tb;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [6:0]    start_size_i = '0;
  logic [15:0]   start_count_i = '0;
  logic [AW-1:0] start_addr_i = '0;
  logic [AW-1:0] fetch_addr_i = '0;
  logic          irq_enter_i = 1'b0;
  logic          irq_return_i = 1'b0;
  logic          redirect_o;
  logic [AW-1:0] redirect_addr_o;
  logic          cfg_err_o;
  logic [31:0]   status_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  hwloop_ctrl #(.ADDR_W(AW)) u_dut (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .start_size_i   (start_size_i),
    .start_count_i  (start_count_i),
    .start_addr_i   (start_addr_i),
    .fetch_addr_i   (fetch_addr_i),
    .irq_enter_i    (irq_enter_i),
    .irq_return_i   (irq_return_i),
    .redirect_o     (redirect_o),
    .redirect_addr_o(redirect_addr_o),
    .cfg_err_o      (cfg_err_o),
    .status_o       (status_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_start(input int addr, input int sz, input int cnt);
    start_i       = 1'b1;
    start_addr_i  = AW'(addr);
    start_size_i  = 7'(sz);
    start_count_i = 16'(cnt);
    tick();
    start_i = 1'b0;
  endtask

  task automatic run_loop(input int addr, input int sz, input int cnt);
    int pc, rem, endA, passes;
    bit done, exp_r;
    do_start(addr, sz, cnt);
    endA = addr + sz - 1;
    chk(status_o[30] == 1'b1, "R3", "active", status_o[30], 1);
    chk(status_o[29:23] == 7'(sz), "R3", "size", status_o[29:23], sz);
    chk(status_o[22:16] == 7'(endA), "R2", "end field", status_o[22:16], endA & 127);
    chk(status_o[15:0] == 16'(cnt), "R3", "count", status_o[15:0], cnt);
    pc = addr; rem = cnt; passes = 0; done = 0;
    while (!done) begin
      fetch_addr_i = AW'(pc);
      #1;
      exp_r = (pc == endA) && (rem != 0);
      chk(redirect_o == exp_r, "R5", "redirect", redirect_o, exp_r);
      if (exp_r)
        chk(redirect_addr_o == AW'(addr), "R5", "redirect addr", redirect_addr_o, addr);
      if (pc == endA) begin
        if (rem != 0) begin rem--; pc = addr; passes++; end
        else begin pc++; done = 1; end
      end else pc++;
      tick();
      chk(status_o[15:0] == 16'(rem), "R5", "count", status_o[15:0], rem);
      chk(status_o[30] == !done, "R6", "active", status_o[30], !done);
    end
    chk(passes == cnt, "R6", "redirect total", passes, cnt);
    fetch_addr_i = AW'(endA);
    #1;
    chk(redirect_o == 1'b0, "R7", "idle redirect", redirect_o, 0);
    tick();
    chk(status_o[15:0] == 16'd0, "R7", "idle count", status_o[15:0], 0);
    fetch_addr_i = '0;
  endtask

  initial begin
    int last_size;
    tick(); tick();
    chk(status_o == 32'd0, "R1", "status after reset", status_o, 0);
    chk(cfg_err_o == 1'b0, "R1", "error after reset", cfg_err_o, 0);
    chk(redirect_o == 1'b0, "R1", "redirect after reset", redirect_o, 0);
    rst = 1'b0;

    // R4: every size at both parities
    last_size = 0;
    for (int par = 0; par < 2; par++) begin
      for (int sz = 0; sz < 128; sz++) begin
        bit legal;
        legal = (sz >= 9) || (sz == 8 && par == 1);
        do_start(256 + par, sz, sz);
        chk(cfg_err_o == !legal, "R4", "error pulse", cfg_err_o, !legal);
        chk(status_o[30] == legal, "R4", "active", status_o[30], legal);
        if (legal) begin
          last_size = sz;
          chk(status_o[15:0] == 16'(sz), "R3", "count", status_o[15:0], sz);
          chk(status_o[22:16] == 7'(256 + par + sz - 1), "R2", "end field",
              status_o[22:16], (256 + par + sz - 1) & 127);
        end else begin
          chk(status_o[29:23] == 7'(last_size), "R4", "size kept",
              status_o[29:23], last_size);
        end
        tick();
        chk(cfg_err_o == 1'b0, "R4", "error one cycle", cfg_err_o, 0);
      end
    end

    run_loop(65, 8, 2);
    run_loop(128, 9, 3);
    run_loop(291, 127, 2);
    run_loop(512, 20, 0);
    run_loop(700, 15, 5);

    // R8, R9, R10: interrupt save and restore
    do_start(81, 8, 5);
    fetch_addr_i = AW'(88);
    #1;
    chk(redirect_o == 1'b1, "R5", "redirect before irq", redirect_o, 1);
    tick();
    chk(status_o[15:0] == 16'd4, "R5", "count", status_o[15:0], 4);
    fetch_addr_i = AW'(82);
    irq_enter_i = 1'b1;
    tick();
    irq_enter_i = 1'b0;
    chk(status_o[31:30] == 2'b10, "R8", "shadow/active", status_o[31:30], 2);
    chk(status_o[15:0] == 16'd4, "R8", "count kept", status_o[15:0], 4);
    fetch_addr_i = AW'(88);
    #1;
    chk(redirect_o == 1'b0, "R7", "redirect in handler", redirect_o, 0);
    tick();
    chk(status_o[15:0] == 16'd4, "R7", "count in handler", status_o[15:0], 4);
    irq_return_i = 1'b1;
    tick();
    irq_return_i = 1'b0;
    chk(status_o[31:30] == 2'b01, "R9", "shadow/active", status_o[31:30], 1);
    irq_return_i = 1'b1;
    #1;
    chk(redirect_o == 1'b0, "R10", "redirect with return", redirect_o, 0);
    tick();
    irq_return_i = 1'b0;
    chk(status_o[15:0] == 16'd4, "R10", "count kept", status_o[15:0], 4);
    chk(status_o[31:30] == 2'b00, "R9", "empty shadow restored", status_o[31:30], 0);
    fetch_addr_i = '0;

    do_start(96, 9, 1);
    irq_enter_i = 1'b1;
    do_start(112, 9, 2);
    irq_enter_i = 1'b0;
    chk(status_o[31:30] == 2'b01, "R10", "start over irq", status_o[31:30], 1);
    chk(status_o[15:0] == 16'd2, "R10", "start count", status_o[15:0], 2);
    irq_enter_i = 1'b1;
    irq_return_i = 1'b1;
    tick();
    irq_enter_i = 1'b0;
    irq_return_i = 1'b0;
    chk(status_o[31:30] == 2'b10, "R10", "entry over return", status_o[31:30], 2);
    irq_return_i = 1'b1;
    tick();
    irq_return_i = 1'b0;
    chk(status_o[31:30] == 2'b01, "R9", "restore", status_o[31:30], 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule